// File: doc/BRIEF.md
# Instruction Compaction Encoder

This block takes one 128-bit native instruction and tries to encode it as a 64-bit compact word. Four wide groups of native bits (a control key, a datatype key, a subregister key and two source keys) are each compared in parallel against every entry of a 32-entry table. A match turns the key into a 5-bit index. A small set of scalar fields is copied across unchanged. If any lookup misses, the opcode is a flow-control opcode, or an immediate operand cannot be rebuilt from its short form, the instruction is rejected. A rejected instruction still produces a result, with the success flag low and a compact word of zero.

Two table sets are built in, one for an older and one for a newer instruction generation. The `gen_sel` pin picks between them. The generation also changes how the control key is formed and whether the flag-subregister bit is copied. The table contents are computed from fixed constants, so the same contents are available to any model.

Both sides are valid/ready streams with one register stage between them. An input is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result appears on the next cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` is held low. When `out_ready` is high, the stage accepts a new input in the same cycle as the old result leaves, so a continuous stream runs at one instruction per cycle.

Top module: `insn_compactor`

## Requirements
- R1: While reset is asserted, and after it until the first accepted input, `out_valid`, `cmp_ok` and `cmp_word` are all zero, and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An input accepted at an edge produces `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `cmp_word` and `cmp_ok` do not change.
- R3: Control key. For `gen_sel`=0 it is 17 bits: native bit 31 above native bits 23:8. For `gen_sel`=1 it is 19 bits: native bits 90:89 form key bits 18:17. The index of the matching entry goes to word bits 12:8.
- R4: Datatype key. It is 18 bits: native bits 63:61 above native bits 46:32. Its index goes to word bits 17:13.
- R5: Subregister key. It is 15 bits: native 52:48 in key bits 4:0, native 68:64 in key bits 9:5, and native 100:96 in key bits 14:10. When either source is an immediate, key bits 14:10 are zero. Its index goes to word bits 22:18.
- R6: Source keys. The source-0 key is native bits 88:77 and the source-1 key is native bits 120:109. Both are looked up in the one 12-bit source table. The source-0 index goes to word bits 34:30. For a non-immediate instruction, the source-1 index goes to word bits 39:35.
- R7: Table contents. Entry i of a table is (i*M + A) mod 2^W. The constants are: control M=0x0A3C5, A=0x00100 (W=17) for gen 0 and A=0x40003 (W=19) for gen 1; datatype M=0x1B4D3, W=18, A=0x08000 / 0x20001; subregister M=0x0611, W=15, A=0x0000 / 0x0040; source M=0x2A5, W=12, A=0x001 / 0x800.
- R8: If any required lookup misses, `cmp_ok`=0 and `cmp_word`=0. For an immediate instruction the source-1 lookup is not required.
- R9: Opcodes 0x22, 0x24, 0x25, 0x26, 0x27 and 0x2A (the branch and loop family) always give `cmp_ok`=0 and `cmp_word`=0.
- R10: A source is an immediate when its register-file field equals 2'b11. The source-0 field is native bits 42:41 and the source-1 field is native bits 37:36. The immediate value is native bits 127:96. It is accepted only if its bits 31:12 are all zeros or all ones; otherwise the instruction is rejected.
- R11: For an immediate instruction, word bits 39:35 hold immediate bits 12:8 and word bits 63:56 hold immediate bits 7:0.
- R12: Compact word layout, with the native bit each field comes from:
  - word bits 6:0: opcode (native 6:0)
  - word bit 7: debug bit (native 30)
  - word bit 23: accumulator-write bit (native 29)
  - word bits 27:24: condition modifier (native 27:24)
  - word bit 28: flag subregister (native 89 when `gen_sel`=0, otherwise 0)
  - word bit 29: constant 1
  - word bits 47:40: destination register (native 60:53)
  - word bits 55:48: source-0 register (native 76:69)
  - word bits 63:56: source-1 register (native 108:101) when no source is an immediate

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_sel | input | 1 | Table set and key format: 0 older, 1 newer |
| in_valid | input | 1 | Native instruction present |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| insn | input | 128 | Native instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| cmp_word | output | 64 | Compact word, zero on rejection |
| cmp_ok | output | 1 | Compaction succeeded |

## Verification
The bench goes after the immediate screen at both edges of the sign-replication window. A design that checked the wrong span of bits would accept 0x00001000 or reject 0xFFFFF8CD. It checks that subregister bits 100:96 are dropped from the key when a source is an immediate; a design that kept them would miss the table and reject valid immediates. It also checks the generation split: a control key built the wrong way, or a flag bit copied into the newer format, shows up as a wrong index or a stray bit 28. Last, it holds `out_ready` low while a second instruction waits at the input, which catches a stage that overwrites its result or takes the input early.

// File: rtl/icmp_pkg.sv
package icmp_pkg;

  localparam int NATIVE_W  = 128;
  localparam int CMP_W     = 64;
  localparam int ENTRIES   = 32;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int CTL_KEY_W = 19;
  localparam int DT_KEY_W  = 18;
  localparam int SUB_KEY_W = 15;
  localparam int SRC_KEY_W = 12;
  localparam int KEY_MAX_W = CTL_KEY_W;
  localparam int REG_W     = 8;
  localparam int IMM_W     = 32;

  localparam logic [1:0] IMM_FILE = 2'b11;

  localparam logic [6:0] OP_IF    = 7'h22;
  localparam logic [6:0] OP_ELSE  = 7'h24;
  localparam logic [6:0] OP_ENDIF = 7'h25;
  localparam logic [6:0] OP_DO    = 7'h26;
  localparam logic [6:0] OP_WHILE = 7'h27;
  localparam logic [6:0] OP_HALT  = 7'h2A;

  typedef enum logic [1:0] {TBL_CTL, TBL_DT, TBL_SUB, TBL_SRC} tbl_kind_e;

  typedef struct packed {
    logic [6:0]           opcode;
    logic                 dbg;
    logic                 accw;
    logic [3:0]           cond;
    logic                 flag;
    logic [REG_W-1:0]     dst_reg;
    logic [REG_W-1:0]     src0_reg;
    logic [REG_W-1:0]     src1_reg;
    logic [CTL_KEY_W-1:0] ctl_key;
    logic [DT_KEY_W-1:0]  dt_key;
    logic [SUB_KEY_W-1:0] sub_key;
    logic [SRC_KEY_W-1:0] s0_key;
    logic [SRC_KEY_W-1:0] s1_key;
    logic [IMM_W-1:0]     imm;
    logic                 is_imm;
    logic                 imm_fits;
    logic                 flow_op;
  } native_fields_t;

  // Entry idx of a table: (idx*mul + add) masked to the key width of the generation.
  function automatic logic [KEY_MAX_W-1:0] tbl_entry(tbl_kind_e kind, logic newer,
                                                     int unsigned idx);
    logic [31:0] mul, add, raw;
    int unsigned width;
    unique case (kind)
      TBL_CTL: begin mul = 32'h0A3C5; add = newer ? 32'h40003 : 32'h00100;
                     width = newer ? 19 : 17; end
      TBL_DT:  begin mul = 32'h1B4D3; add = newer ? 32'h20001 : 32'h08000;
                     width = 18; end
      TBL_SUB: begin mul = 32'h00611; add = newer ? 32'h00040 : 32'h00000;
                     width = 15; end
      default: begin mul = 32'h002A5; add = newer ? 32'h00800 : 32'h00001;
                     width = 12; end
    endcase
    raw = 32'(idx) * mul + add;
    raw = raw & ((32'h1 << width) - 32'h1);
    return raw[KEY_MAX_W-1:0];
  endfunction

endpackage

// File: rtl/icmp_field_split.sv
module icmp_field_split
  import icmp_pkg::*;
(
  input  logic [NATIVE_W-1:0] insn,
  input  logic                newer,
  output native_fields_t      f
);

  logic imm_any;
  logic [IMM_W-1:0] imm_v;

  assign imm_any = (insn[42:41] == IMM_FILE) || (insn[37:36] == IMM_FILE);
  assign imm_v   = insn[127:96];

  always_comb begin
    f          = '0;
    f.opcode   = insn[6:0];
    f.dbg      = insn[30];
    f.accw     = insn[29];
    f.cond     = insn[27:24];
    f.flag     = insn[89];
    f.dst_reg  = insn[60:53];
    f.src0_reg = insn[76:69];
    f.src1_reg = insn[108:101];
    f.ctl_key  = newer ? {insn[90:89], insn[31], insn[23:8]}
                       : {2'b00, insn[31], insn[23:8]};
    f.dt_key   = {insn[63:61], insn[46:32]};
    f.sub_key  = {(imm_any ? 5'b00000 : insn[100:96]), insn[68:64], insn[52:48]};
    f.s0_key   = insn[88:77];
    f.s1_key   = insn[120:109];
    f.imm      = imm_v;
    f.is_imm   = imm_any;
    f.imm_fits = (&imm_v[31:12]) || !(|imm_v[31:12]);
    f.flow_op  = insn[6:0] inside {OP_IF, OP_ELSE, OP_ENDIF, OP_DO, OP_WHILE, OP_HALT};
  end

endmodule

// File: rtl/icmp_cam.sv
module icmp_cam
  import icmp_pkg::*;
#(
  parameter tbl_kind_e KIND  = TBL_CTL,
  parameter int        KEY_W = CTL_KEY_W
) (
  input  logic             newer,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam logic [KEY_W-1:0] ENT_OLD = KEY_W'(tbl_entry(KIND, 1'b0, i));
    localparam logic [KEY_W-1:0] ENT_NEW = KEY_W'(tbl_entry(KIND, 1'b1, i));
    assign match[i] = (key == (newer ? ENT_NEW : ENT_OLD));
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (match[j]) idx = IDX_W'(j);
    end
  end

endmodule

// File: rtl/insn_compactor.sv
module insn_compactor
  import icmp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NATIVE_W-1:0] insn,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CMP_W-1:0]    cmp_word,
  output logic                cmp_ok
);

  native_fields_t f;

  icmp_field_split u_split (.insn(insn), .newer(gen_sel), .f(f));

  logic ctl_hit, dt_hit, sub_hit;
  logic [IDX_W-1:0] ctl_idx, dt_idx, sub_idx;

  icmp_cam #(.KIND(TBL_CTL), .KEY_W(CTL_KEY_W)) u_ctl
    (.newer(gen_sel), .key(f.ctl_key), .hit(ctl_hit), .idx(ctl_idx));
  icmp_cam #(.KIND(TBL_DT), .KEY_W(DT_KEY_W)) u_dt
    (.newer(gen_sel), .key(f.dt_key), .hit(dt_hit), .idx(dt_idx));
  icmp_cam #(.KIND(TBL_SUB), .KEY_W(SUB_KEY_W)) u_sub
    (.newer(gen_sel), .key(f.sub_key), .hit(sub_hit), .idx(sub_idx));

  localparam int NSRC = 2;
  logic [SRC_KEY_W-1:0] src_key [NSRC];
  logic [NSRC-1:0]      src_hit;
  logic [IDX_W-1:0]     src_idx [NSRC];

  assign src_key[0] = f.s0_key;
  assign src_key[1] = f.s1_key;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    icmp_cam #(.KIND(TBL_SRC), .KEY_W(SRC_KEY_W)) u_src
      (.newer(gen_sel), .key(src_key[s]), .hit(src_hit[s]), .idx(src_idx[s]));
  end

  logic             ok_c;
  logic [IDX_W-1:0] s1_field;
  logic [REG_W-1:0] s1_reg_field;
  logic [CMP_W-1:0] word_c;

  always_comb begin
    ok_c = ctl_hit && dt_hit && sub_hit && src_hit[0]
        && (f.is_imm || src_hit[1])
        && !f.flow_op
        && (!f.is_imm || f.imm_fits);
    s1_field     = f.is_imm ? f.imm[12:8] : src_idx[1];
    s1_reg_field = f.is_imm ? f.imm[7:0]  : f.src1_reg;
    word_c = {s1_reg_field, f.src0_reg, f.dst_reg,
              s1_field, src_idx[0],
              1'b1, (gen_sel ? 1'b0 : f.flag), f.cond, f.accw,
              sub_idx, dt_idx, ctl_idx, f.dbg, f.opcode};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cmp_word  <= '0;
      cmp_ok    <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      cmp_ok    <= ok_c;
      cmp_word  <= ok_c ? word_c : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/icmp_checker.sv
module icmp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] cmp_word,
  input logic        cmp_ok
);

  // R2
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cmp_word) && $stable(cmp_ok));

  // R8
  reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cmp_ok |-> cmp_word == 64'h0);

  // R12
  compact_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp_ok |-> cmp_word[29]);

  // R9
  no_flow_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cmp_ok |-> !(cmp_word[6:0] inside {7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A}));

endmodule

bind insn_compactor icmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .cmp_word(cmp_word), .cmp_ok(cmp_ok)
);

// File: tb/tb_insn_compactor.sv
`timescale 1ns/1ps
module tb_insn_compactor;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gen_sel = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] insn = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  cmp_word;
  logic         cmp_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_compactor dut (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .in_valid(in_valid),
    .in_ready(in_ready), .insn(insn), .out_valid(out_valid),
    .out_ready(out_ready), .cmp_word(cmp_word), .cmp_ok(cmp_ok)
  );

  // Table contents per R7. kind: 0 control, 1 datatype, 2 subregister, 3 source
  function automatic logic [31:0] tent(int kind, logic g, int i);
    logic [31:0] m, a; int w;
    case (kind)
      0: begin m = 32'h0A3C5; a = g ? 32'h40003 : 32'h00100; w = g ? 19 : 17; end
      1: begin m = 32'h1B4D3; a = g ? 32'h20001 : 32'h08000; w = 18; end
      2: begin m = 32'h00611; a = g ? 32'h00040 : 32'h00000; w = 15; end
      default: begin m = 32'h002A5; a = g ? 32'h00800 : 32'h00001; w = 12; end
    endcase
    return (32'(i) * m + a) & ((32'h1 << w) - 1);
  endfunction

  // Returns {hit, idx}
  function automatic logic [5:0] tfind(int kind, logic g, logic [31:0] key);
    for (int i = 0; i < 32; i++)
      if (tent(kind, g, i) == key) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  // Reference model from R3..R12; returns {ok, word}
  function automatic logic [64:0] model(logic [127:0] n, logic g);
    logic imm; logic [31:0] iv; logic [5:0] c, d, s, a, b;
    logic ok; logic [63:0] w;
    imm = (n[42:41] == 2'b11) || (n[37:36] == 2'b11);
    iv  = n[127:96];
    c = tfind(0, g, g ? {13'd0, n[90:89], n[31], n[23:8]} : {15'd0, n[31], n[23:8]});
    d = tfind(1, g, {14'd0, n[63:61], n[46:32]});
    s = tfind(2, g, {17'd0, (imm ? 5'd0 : n[100:96]), n[68:64], n[52:48]});
    a = tfind(3, g, {20'd0, n[88:77]});
    b = tfind(3, g, {20'd0, n[120:109]});
    ok = c[5] && d[5] && s[5] && a[5] && (imm || b[5])
      && !(n[6:0] inside {7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A})
      && (!imm || iv[31:12] == 20'h0 || iv[31:12] == 20'hFFFFF);
    w = '0;
    w[6:0] = n[6:0]; w[7] = n[30]; w[12:8] = c[4:0]; w[17:13] = d[4:0];
    w[22:18] = s[4:0]; w[23] = n[29]; w[27:24] = n[27:24];
    w[28] = g ? 1'b0 : n[89]; w[29] = 1'b1;
    w[34:30] = a[4:0]; w[39:35] = imm ? iv[12:8] : b[4:0];
    w[47:40] = n[60:53]; w[55:48] = n[76:69];
    w[63:56] = imm ? iv[7:0] : n[108:101];
    return {ok, ok ? w : 64'h0};
  endfunction

  function automatic logic [127:0] build(logic g, logic [6:0] op, int ci, int di,
                                         int si, int s0, int s1);
    logic [127:0] n; logic [31:0] k;
    n = '0;
    n[6:0] = op;
    n[30] = ci[0]; n[29] = di[0]; n[27:24] = 4'(s0);
    k = tent(0, g, ci); n[23:8] = k[15:0]; n[31] = k[16];
    if (g) n[90:89] = k[18:17]; else begin n[90] = 1'b1; n[89] = si[0]; end
    k = tent(1, g, di); n[46:32] = k[14:0]; n[63:61] = k[17:15];
    k = tent(2, g, si); n[52:48] = k[4:0]; n[68:64] = k[9:5]; n[100:96] = k[14:10];
    k = tent(3, g, s0); n[88:77] = k[11:0];
    k = tent(3, g, s1); n[120:109] = k[11:0];
    n[60:53] = 8'hA0 + 8'(ci); n[76:69] = 8'h30 + 8'(s1); n[108:101] = 8'hC5 ^ 8'(di);
    return n;
  endfunction

  function automatic bit dt_is_imm(logic g, int i);
    logic [31:0] k; k = tent(1, g, i);
    return (k[10:9] == 2'b11) || (k[5:4] == 2'b11);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic g, logic [127:0] n);
    @(negedge clk);
    gen_sel = g; insn = n; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cmp(string req, logic g, logic [127:0] n);
    logic [64:0] e;
    e = model(n, g);
    send(g, n);
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, {63'd0, cmp_ok}, {63'd0, e[64]});
    check(req, cmp_word, e[63:0]);
  endtask

  typedef struct packed {
    logic g; logic [6:0] op; logic [4:0] ci, di, si, s0, s1; logic [1:0] cor;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 7'h01, 5'd0,  5'd1,  5'd2,  5'd3,  5'd4,  2'd0},
    '{1'b1, 7'h01, 5'd5,  5'd6,  5'd7,  5'd8,  5'd9,  2'd0},
    '{1'b0, 7'h40, 5'd31, 5'd30, 5'd29, 5'd28, 5'd27, 2'd0},
    '{1'b1, 7'h10, 5'd12, 5'd14, 5'd16, 5'd18, 5'd20, 2'd0},
    '{1'b0, 7'h05, 5'd3,  5'd7,  5'd11, 5'd13, 5'd17, 2'd1},
    '{1'b1, 7'h05, 5'd4,  5'd8,  5'd12, 5'd16, 5'd24, 2'd2},
    '{1'b0, 7'h41, 5'd9,  5'd2,  5'd5,  5'd21, 5'd22, 2'd3},
    '{1'b1, 7'h27, 5'd1,  5'd2,  5'd3,  5'd4,  5'd5,  2'd0},
    '{1'b0, 7'h7F, 5'd15, 5'd16, 5'd17, 5'd18, 5'd19, 2'd0},
    '{1'b1, 7'h3C, 5'd26, 5'd25, 5'd23, 5'd0,  5'd31, 2'd0}
  };

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] n, na, nb;
    logic [64:0] ea, eb;
    int dn0, dn1, di0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {61'd0, out_valid, cmp_ok, in_ready}, 64'd1);
    check("R1", cmp_word, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {61'd0, out_valid, cmp_ok, in_ready}, 64'd1);

    // Vector table: R3 R4 R6 R7 R8 R9 R12 under varied keys and corruptions
    foreach (VEC[v]) begin
      n = build(VEC[v].g, VEC[v].op, VEC[v].ci, VEC[v].di, VEC[v].si, VEC[v].s0, VEC[v].s1);
      case (VEC[v].cor)
        2'd1: n[8]   = ~n[8];
        2'd2: n[32]  = ~n[32];
        2'd3: n[109] = ~n[109];
        default: ;
      endcase
      send_cmp("R3/R4/R6/R8/R12 vector", VEC[v].g, n);
    end

    // Pick datatype indices: non-immediate and immediate
    dn0 = -1; dn1 = -1; di0 = -1;
    for (int i = 0; i < 32; i++) begin
      if (dn0 < 0 && !dt_is_imm(1'b0, i)) dn0 = i;
      if (dn1 < 0 && !dt_is_imm(1'b1, i)) dn1 = i;
      if (di0 < 0 && dt_is_imm(1'b0, i)) di0 = i;
    end
    check("R10 immediate datatype available", {63'd0, di0 >= 0}, 64'd1);
    if (dn0 < 0) dn0 = 0;
    if (dn1 < 0) dn1 = 0;
    if (di0 < 0) di0 = 0;

    // R3 R4 R6 R12 explicit field placement, older generation
    n = build(1'b0, 7'h11, 6, dn0, 3, 9, 14);
    send(1'b0, n);
    check("R3 ctl idx", {59'd0, cmp_word[12:8]}, 64'd6);
    check("R4 dt idx",  {59'd0, cmp_word[17:13]}, 64'(dn0));
    check("R5 sub idx", {59'd0, cmp_word[22:18]}, 64'd3);
    check("R6 src idx", {54'd0, cmp_word[39:35], cmp_word[34:30]}, {54'd0, 5'd14, 5'd9});
    check("R12 flag copied old gen", {63'd0, cmp_word[28]}, {63'd0, n[89]});
    check("R12 regs", {40'd0, cmp_word[63:40]}, {40'd0, n[108:101], n[76:69], n[60:53]});

    // R12 newer generation: flag bit not copied; R3 bits 90:89 in key
    n = build(1'b1, 7'h11, 30, dn1, 4, 1, 2);
    send(1'b1, n);
    check("R3 new gen ctl idx", {59'd0, cmp_word[12:8]}, 64'd30);
    check("R12 flag zero new gen", {63'd0, cmp_word[28]}, 64'd0);
    // R3: corrupt native bit 90 in newer gen -> control key misses
    n[90] = ~n[90];
    send_cmp("R3 bit90 in new key", 1'b1, n);
    // R3: bit 90 ignored in older gen
    n = build(1'b0, 7'h11, 2, dn0, 4, 1, 2);
    n[90] = ~n[90];
    send(1'b0, n);
    check("R3 bit90 ignored old gen", {63'd0, cmp_ok}, 64'd1);

    // R10 R11 R5 immediate handling (subreg index 0 has zero top bits)
    n = build(1'b0, 7'h01, 1, di0, 0, 2, 0);
    n[127:96] = 32'h0000_07AB;
    send(1'b0, n);
    check("R10 small imm ok", {63'd0, cmp_ok}, 64'd1);
    check("R11 imm src1 idx", {59'd0, cmp_word[39:35]}, 64'h07);
    check("R11 imm src1 reg", {56'd0, cmp_word[63:56]}, 64'hAB);
    check("R5 imm drops top subreg bits", {59'd0, cmp_word[22:18]}, 64'd0);
    n[127:96] = 32'hFFFF_F8CD;
    send_cmp("R10 negative imm ok", 1'b0, n);
    check("R10 negative imm ok flag", {63'd0, cmp_ok}, 64'd1);
    n[127:96] = 32'h0000_1000;
    send(1'b0, n);
    check("R10 imm 0x1000 rejected", {63'd0, cmp_ok}, 64'd0);
    n[127:96] = 32'hFFFF_0FFF;
    send(1'b0, n);
    check("R10 imm mixed high rejected", {63'd0, cmp_ok}, 64'd0);
    check("R8 reject word zero", cmp_word, 64'h0);

    // R9 each flow opcode rejected
    foreach (VEC[k]) begin
      if (k < 6) begin
        logic [6:0] op;
        case (k)
          0: op = 7'h22; 1: op = 7'h24; 2: op = 7'h25;
          3: op = 7'h26; 4: op = 7'h27; default: op = 7'h2A;
        endcase
        n = build(1'b0, op, 0, dn0, 1, 1, 1);
        send(1'b0, n);
        check("R9 flow opcode", {63'd0, cmp_ok}, 64'd0);
      end
    end

    // R8 each key miss
    na = build(1'b1, 7'h02, 7, dn1, 8, 9, 10);
    n = na; n[50] = ~n[50];  send_cmp("R8 subreg miss", 1'b1, n);
    n = na; n[80] = ~n[80];  send_cmp("R8 src0 miss", 1'b1, n);
    n = na; n[115] = ~n[115]; send_cmp("R8 src1 miss", 1'b1, n);

    // R2 back-pressure
    na = build(1'b0, 7'h03, 11, dn0, 5, 6, 7);
    nb = build(1'b0, 7'h04, 12, dn0, 6, 7, 8);
    ea = model(na, 1'b0); eb = model(nb, 1'b0);
    @(negedge clk);
    out_ready = 1'b0; gen_sel = 1'b0; insn = na; in_valid = 1'b1;
    @(negedge clk);
    insn = nb;
    check("R2 result A", cmp_word, ea[63:0]);
    check("R2 in_ready low when stalled", {63'd0, in_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R2 held A", {cmp_word[62:0], out_valid}, {ea[62:0], 1'b1});
    out_ready = 1'b1;
    #1;
    check("R2 in_ready follows out_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 result B", cmp_word, eb[63:0]);
    @(negedge clk);
    check("R2 out_valid drops", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule